// File: doc/BRIEF.md
# Four-Channel Period-Synchronous PWM Controller

This block drives four pulse-width outputs that share one free-running period counter. Each channel holds a duty value split into a coarse part and a fine part. The period is cut into 2^FINE_W subsections of 2^COARSE_W clocks each. In every subsection the output is high for `coarse` clocks. A subset of subsections, chosen by the fine value, is one clock longer. Over one period, the high time is therefore 2^FINE_W*coarse + fine clocks.

Software writes each channel through a decoded byte-wide write port. A low-byte write carries the fine duty, an output-select flag and an arm flag. A high-byte write then carries the coarse duty. Several things wait for the last clock of the current period before they take effect: the channel's enable, its new duty, the global output-control pin and the reset request. A reset request clears every channel and holds all outputs undriven until each channel is given fresh data. High impedance is modelled by a per-channel output-enable.

Top module: `quad_pwm_ctrl`

## Requirements
- R1: A period is 2^(COARSE_W+FINE_W) clocks, counted from 0 after `rst`. While a channel drives, its number of high clocks in one period is 2^FINE_W*coarse + fine. A new duty value first takes effect in the period that starts after the write.
- R2: Low-byte writes (`wr_hi`=0) use this layout: bit 3 is the output-select flag, bit 0 is the arm flag, and bits 4 and up hold the fine duty. The fine duty is stored and the channel is armed only when bits 3 and 0 are both 1. Any other low-byte write disarms the channel. A low-byte write with bit 3 = 0 also deselects the channel's output.
- R3: A high-byte write to a channel that is not armed has no effect.
- R4: A high-byte write to an armed channel stores bits COARSE_W-1:0 as the coarse duty, marks the channel's data valid, and disarms the channel.
- R5: A change to a channel's output-select flag reaches `pwm_oe` only after the current period ends.
- R6: `oc_in` is sampled at each period boundary. That sample governs all four channels for the whole following period.
- R7: `pwm_oe[i]` is 1 exactly when channel i has valid data, is selected, and the sampled `oc_in` is 1. When `pwm_oe[i]` is 0, `pwm_o[i]` is 0.
- R8: While a channel is undriven, its registers keep their contents and accept new writes.
- R9: A low level on `rst_req_n`, even for one clock, is acted on at the end of the current period. It then clears every channel's duty, select and valid state, and all `pwm_oe` go to 0.
- R10: After that boundary, writes are ignored for as long as `rst_req_n` stays low. The first clock with `rst_req_n` high restarts the period counter at 0. All outputs stay undriven until a channel is rewritten.
- R11: Synchronous `rst` clears all state and drives `pwm_o` and `pwm_oe` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | $clog2(NCH) | Channel addressed by the write |
| wr_hi | input | 1 | 1 selects the high byte, 0 the low byte |
| wr_data | input | 8 | Write data |
| oc_in | input | 1 | Global output control, 1 lets channels drive |
| rst_req_n | input | 1 | Active-low period-synchronous reset request |
| pwm_o | output | NCH | PWM levels |
| pwm_oe | output | NCH | Per-channel drive enable (0 = high impedance) |

## Verification
The bench measures the high-clock count over full periods, including the extremes of zero duty and one clock short of full duty. A wrong subsection spreading rule or an off-by-one in the comparison would change that count. It changes the select flag and `oc_in` in the middle of a period and checks `pwm_oe` on the last clock of that period and again in the next period. A design that applied these changes at once would drop the outputs early. It sends a one-clock reset pulse that is gone well before the boundary, and it writes while the reset is being held. A design that sampled the reset only at the boundary would keep driving. One that accepted writes while held would wake a channel. A high-byte write after a disarming low-byte write must leave the measured duty unchanged.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;
  // low-byte field positions decoded by every channel
  localparam int LO_SEL_BIT  = 3;
  localparam int LO_ARM_BIT  = 0;
  localparam int LO_FINE_LSB = 4;
endpackage

// File: rtl/qpwm_timer.sv
module qpwm_timer #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic [PW-1:0] cnt,
  output logic          bnd
);
  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign bnd = &cnt;
endmodule

// File: rtl/qpwm_chreg.sv
module qpwm_chreg
  import qpwm_pkg::*;
#(
  parameter int CW = 8,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          bnd,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [7:0]    wr_data,
  output logic [CW-1:0] coarse_act,
  output logic [FW-1:0] fine_act,
  output logic          en_act,
  output logic          valid_act
);
  logic [CW-1:0] coarse;
  logic [FW-1:0] fine;
  logic          en_req, valid, armed;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      coarse     <= '0;
      fine       <= '0;
      en_req     <= 1'b0;
      valid      <= 1'b0;
      armed      <= 1'b0;
      coarse_act <= '0;
      fine_act   <= '0;
      en_act     <= 1'b0;
      valid_act  <= 1'b0;
    end else begin
      if (wr_lo) begin
        en_req <= wr_data[LO_SEL_BIT];
        armed  <= wr_data[LO_SEL_BIT] & wr_data[LO_ARM_BIT];
        if (wr_data[LO_SEL_BIT] && wr_data[LO_ARM_BIT])
          fine <= wr_data[LO_FINE_LSB +: FW];
      end
      if (wr_hi && armed) begin
        coarse <= wr_data[CW-1:0];
        valid  <= 1'b1;
        armed  <= 1'b0;
      end
      if (bnd) begin
        coarse_act <= coarse;
        fine_act   <= fine;
        en_act     <= en_req;
        valid_act  <= valid;
      end
    end
  end

  // R3
  hi_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !armed && !clr) |=> ($stable(coarse) && $stable(valid)));

  // R5
  en_defer_chk: assert property (@(posedge clk) disable iff (rst)
    (!bnd && !clr) |=> $stable(en_act));
endmodule

// File: rtl/qpwm_wave.sv
module qpwm_wave #(
  parameter int CW = 8,
  parameter int FW = 4
) (
  input  logic [CW-1:0] tick,
  input  logic [FW-1:0] sub,
  input  logic [CW-1:0] coarse,
  input  logic [FW-1:0] fine,
  output logic          lvl
);
  logic [FW-1:0] rev;
  logic          ext;

  // subsections are lengthened in bit-reversed order so they spread evenly
  always_comb begin
    rev = '0;
    for (int b = 0; b < FW; b++) rev[b] = sub[FW-1-b];
    ext = (rev < fine);
    lvl = ({1'b0, tick} < ({1'b0, coarse} + {{CW{1'b0}}, ext}));
  end
endmodule

// File: rtl/quad_pwm_ctrl.sv
module quad_pwm_ctrl #(
  parameter int NCH      = 4,
  parameter int COARSE_W = 8,
  parameter int FINE_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [$clog2(NCH)-1:0]  wr_ch,
  input  logic                    wr_hi,
  input  logic [7:0]              wr_data,
  input  logic                    oc_in,
  input  logic                    rst_req_n,
  output logic [NCH-1:0]          pwm_o,
  output logic [NCH-1:0]          pwm_oe
);
  localparam int PW  = COARSE_W + FINE_W;
  localparam int CHW = $clog2(NCH);

  logic [PW-1:0]  cnt;
  logic           bnd, clr, restart;
  logic           rst_pend, rst_hold, oc_act;
  logic [NCH-1:0] en_act_v, valid_act_v, lvl_v, drive_v;

  assign restart = rst_hold & rst_req_n;
  assign clr     = bnd & ~rst_hold & (rst_pend | ~rst_req_n);

  qpwm_timer #(.PW(PW)) u_timer (
    .clk(clk), .rst(rst), .restart(restart), .cnt(cnt), .bnd(bnd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_pend <= 1'b0;
      rst_hold <= 1'b0;
      oc_act   <= 1'b0;
    end else begin
      if (rst_hold) begin
        rst_pend <= 1'b0;
        if (rst_req_n) rst_hold <= 1'b0;
      end else if (bnd) begin
        rst_pend <= 1'b0;
        rst_hold <= rst_pend | ~rst_req_n;
      end else if (!rst_req_n) begin
        rst_pend <= 1'b1;
      end
      if (bnd) oc_act <= oc_in;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic                wsel;
    logic [COARSE_W-1:0] coarse_a;
    logic [FINE_W-1:0]   fine_a;

    assign wsel = wr_en & ~rst_hold & (wr_ch == CHW'(i));

    qpwm_chreg #(.CW(COARSE_W), .FW(FINE_W)) u_reg (
      .clk(clk), .rst(rst), .clr(clr), .bnd(bnd),
      .wr_lo(wsel & ~wr_hi), .wr_hi(wsel & wr_hi), .wr_data(wr_data),
      .coarse_act(coarse_a), .fine_act(fine_a),
      .en_act(en_act_v[i]), .valid_act(valid_act_v[i])
    );

    qpwm_wave #(.CW(COARSE_W), .FW(FINE_W)) u_wave (
      .tick(cnt[COARSE_W-1:0]), .sub(cnt[PW-1:COARSE_W]),
      .coarse(coarse_a), .fine(fine_a), .lvl(lvl_v[i])
    );
  end

  assign drive_v = valid_act_v & en_act_v & {NCH{oc_act}};

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_oe <= '0;
      pwm_o  <= '0;
    end else begin
      pwm_oe <= drive_v;
      pwm_o  <= lvl_v & drive_v;
    end
  end

  // R6
  oc_sample_chk: assert property (@(posedge clk) disable iff (rst)
    !bnd |=> $stable(oc_act));

  // R9
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> ##1 (pwm_oe == '0));

  // R10
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    rst_hold |=> (pwm_oe == '0 && $stable(valid_act_v)));

  // R7
  o_gated_chk: assert property (@(posedge clk) disable iff (rst)
    ((pwm_o & ~pwm_oe) == '0));
endmodule

// File: tb/quad_pwm_ctrl_tb.sv
`timescale 1ns/1ps
module quad_pwm_ctrl_tb;
  localparam int NCH = 4;
  localparam int CW  = 3;
  localparam int FW  = 2;
  localparam int PER = 1 << (CW + FW);
  localparam int MAX = PER - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_ch = '0;
  logic wr_hi = 1'b0;
  logic [7:0] wr_data = '0;
  logic oc_in = 1'b0;
  logic rn = 1'b1;
  logic [NCH-1:0] pwm_o, pwm_oe;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  quad_pwm_ctrl #(.NCH(NCH), .COARSE_W(CW), .FINE_W(FW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_hi(wr_hi),
    .wr_data(wr_data), .oc_in(oc_in), .rst_req_n(rn),
    .pwm_o(pwm_o), .pwm_oe(pwm_oe)
  );

  // bench timing model of the period counter, from R1, R9, R10
  int mcnt = 0;
  bit mhold = 0, mpend = 0;
  always @(posedge clk) begin
    if (rst) begin
      mcnt <= 0; mhold <= 0; mpend <= 0;
    end else if (mhold) begin
      mpend <= 0;
      if (rn) begin mhold <= 0; mcnt <= 0; end
      else mcnt <= (mcnt + 1) % PER;
    end else begin
      mcnt <= (mcnt + 1) % PER;
      if (mcnt == MAX) begin
        mhold <= mpend | ~rn;
        mpend <= 0;
      end else if (!rn) mpend <= 1;
    end
  end

  function automatic int exp_hc(int c, int f);
    return (1 << FW) * c + f;
  endfunction

  function automatic logic [7:0] lo_byte(bit sel, bit arm, int f);
    logic [7:0] v;
    v = '0;
    v[3] = sel;
    v[0] = arm;
    v[7:4] = 4'(f);
    return v;
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(int ch, bit hi, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 2'(ch); wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic program_ch(int ch, int c, int f);
    wr(ch, 1'b0, lo_byte(1'b1, 1'b1, f));
    wr(ch, 1'b1, 8'(c));
  endtask

  task automatic goto(int k);
    @(negedge clk);
    while (mcnt != k) @(negedge clk);
  endtask

  // measure the period that starts after all earlier writes
  task automatic measure(int ch, output int hc, output bit oe_all);
    goto(2);
    goto(1);
    hc = 0;
    oe_all = 1'b1;
    for (int n = 0; n < PER; n++) begin
      if (n != 0) @(negedge clk);
      if (pwm_oe[ch] && pwm_o[ch]) hc++;
      if (!pwm_oe[ch]) oe_all = 1'b0;
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    int hc;
    bit oe_all;
    void'($urandom(32'h5a17));
    repeat (4) @(negedge clk);
    chk("R11 oe after rst", int'(pwm_oe), 0);
    chk("R11 o after rst", int'(pwm_o), 0);
    rst = 1'b0;
    oc_in = 1'b1;

    // directed duty
    program_ch(0, 5, 3);
    measure(0, hc, oe_all);
    chk("R1 duty c5 f3", hc, exp_hc(5, 3));
    chk("R7 ch0 driven", int'(oe_all), 1);
    chk("R7 others idle", int'(pwm_oe[3:1]), 0);

    program_ch(0, 0, 0);
    measure(0, hc, oe_all);
    chk("R1 duty zero", hc, 0);
    program_ch(0, 7, 3);
    measure(0, hc, oe_all);
    chk("R1 duty max", hc, exp_hc(7, 3));
    program_ch(0, 0, 1);
    measure(0, hc, oe_all);
    chk("R1 duty one", hc, 1);

    // random duties on random channels
    for (int it = 0; it < 8; it++) begin
      int ch, c, f;
      ch = int'($urandom_range(3, 0));
      c  = int'($urandom_range(7, 0));
      f  = int'($urandom_range(3, 0));
      program_ch(ch, c, f);
      measure(ch, hc, oe_all);
      chk("R4 random duty", hc, exp_hc(c, f));
      chk("R7 random drive", int'(oe_all), 1);
    end

    // R3: high byte after a select-only (disarming) write
    program_ch(1, 4, 2);
    wr(1, 1'b0, lo_byte(1'b1, 1'b0, 1));
    wr(1, 1'b1, 8'd1);
    measure(1, hc, oe_all);
    chk("R3 unarmed hi ignored", hc, exp_hc(4, 2));

    // R2: arm then a bit3=0 write disarms; fine from the arm write is kept
    wr(1, 1'b0, lo_byte(1'b1, 1'b1, 3));
    wr(1, 1'b0, lo_byte(1'b0, 1'b1, 0));
    wr(1, 1'b1, 8'd6);
    wr(1, 1'b0, lo_byte(1'b1, 1'b0, 0));
    measure(1, hc, oe_all);
    chk("R2 disarm keeps coarse", hc, exp_hc(4, 3));

    // R5: deselect mid-period is deferred
    program_ch(0, 3, 1);
    measure(0, hc, oe_all);
    goto(5);
    wr(0, 1'b0, lo_byte(1'b0, 1'b0, 0));
    goto(MAX);
    chk("R5 oe held to period end", int'(pwm_oe[0]), 1);
    goto(2);
    chk("R5 oe off next period", int'(pwm_oe[0]), 0);
    wr(0, 1'b0, lo_byte(1'b1, 1'b0, 0));
    measure(0, hc, oe_all);
    chk("R5 reselect restores duty", hc, exp_hc(3, 1));

    // R6: oc change mid-period is deferred
    goto(5);
    oc_in = 1'b0;
    goto(MAX);
    chk("R6 oc low held to period end", int'(pwm_oe[0]), 1);
    goto(2);
    chk("R6 all undriven next period", int'(pwm_oe), 0);

    // R8: rewrite while undriven, then drive again
    program_ch(0, 2, 1);
    goto(3);
    chk("R8 still undriven", int'(pwm_oe), 0);
    oc_in = 1'b1;
    measure(0, hc, oe_all);
    chk("R8 rewritten duty", hc, exp_hc(2, 1));
    chk("R8 driven again", int'(oe_all), 1);

    // R9: one-clock reset pulse mid-period
    goto(4);
    rn = 1'b0;
    @(negedge clk);
    rn = 1'b1;
    goto(MAX);
    chk("R9 reset deferred", int'(pwm_oe[0]), 1);
    goto(2);
    chk("R9 all undriven after boundary", int'(pwm_oe), 0);
    goto(2);
    chk("R10 stays undriven", int'(pwm_oe), 0);
    wr(2, 1'b0, lo_byte(1'b1, 1'b0, 0));
    wr(2, 1'b1, 8'd5);
    measure(2, hc, oe_all);
    chk("R10 hi without arm after reset", int'(pwm_oe), 0);
    program_ch(2, 6, 2);
    measure(2, hc, oe_all);
    chk("R10 rewritten channel duty", hc, exp_hc(6, 2));
    chk("R10 only rewritten channel", int'(pwm_oe), 4);

    // R10: writes during held reset are ignored
    goto(3);
    rn = 1'b0;
    goto(5);
    goto(5);
    program_ch(3, 4, 0);
    goto(10);
    rn = 1'b1;
    goto(2);
    goto(2);
    chk("R10 held writes ignored", int'(pwm_oe), 0);

    finish_up();
  end
endmodule